// File: doc/BRIEF.md
# Merging Store Buffer

This block sits between a cache and the next level of memory and absorbs stores so the processor can continue without waiting for each memory write. It has a small number of slots. Each slot covers one aligned block of several words and keeps a data word and a valid bit for every word position. The slots form a queue.

When a store arrives for a block that already has a pending slot, the store is folded into that slot: it sets the word's valid bit and writes the word's data. A new slot is used only when no pending slot matches. Addresses in the I/O region are never combined, so every I/O store keeps its own slot. The oldest slot is offered to memory over a valid/ready pair, with one write mask bit per word. While a slot is offered it is frozen and cannot take merges. When a store can neither merge nor get a free slot, the block asserts a stall and does not take the store.

With the default parameters there are 4 slots. Each slot holds four 32-bit words. Addresses are byte addresses.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `mem_valid` is low, and `st_stall` is low while `st_valid` is low.
- R2: A store that finds a free slot is accepted without stall. The store's block is `st_addr[31:4]` and its word is `st_addr[3:2]`. The store later appears at the memory side with `mem_addr` = block base (low 4 bits zero) and the single `mem_wmask` bit for its word set. Word i sits in `mem_data[32*i+31:32*i]`, and unwritten words read as zero.
- R3: A store to a non-I/O block that has a pending slot, other than the slot currently offered to memory, merges into that slot: the masks OR together, and the block drains as one write.
- R4: A merged store to a word already valid in the slot replaces that word's data, so the newest data wins.
- R5: A store with address bit 31 set (I/O) always takes its own slot and is never merged. Every I/O drain therefore has exactly one mask bit set.
- R6: Slots drain to memory in the order they were allocated, oldest first.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_data` and `mem_wmask` hold steady. A store to the block of the offered slot takes a new slot instead of merging.
- R8: When all slots are occupied and the store cannot merge, `st_stall` is high and the store is not taken.
- R9: A store that merges into a non-offered slot is accepted without stall even when all slots are occupied.
- R10: A slot leaves the buffer on a cycle with `mem_valid` and `mem_ready` both high. `mem_valid` is low once every slot has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data word |
| st_stall | output | 1 | Store not accepted this cycle |
| mem_valid | output | 1 | Oldest slot offered to memory |
| mem_ready | input | 1 | Memory takes the offered slot |
| mem_addr | output | 32 | Block base address of the offered slot |
| mem_data | output | 128 | Word data of the offered slot |
| mem_wmask | output | 4 | Per-word write enables of the offered slot |

## Verification
The assertions assume that the store side treats `st_stall` as a refusal and does not count a stalled store as done. They also assume that `mem_ready` only matters while `mem_valid` is high. The bench drives every store for a single cycle, starting at a falling edge, and reads the stall before the next rising edge. It raises `mem_ready` only on the cycles where it expects and checks a drain. A full buffer is built by holding `mem_ready` low, which drives the stall and frozen-head cases without breaking those assumptions.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
    parameter int ADDR_W  = 32;
    parameter int DATA_W  = 32;
    parameter int WORDS   = 4;
    parameter int ENTRIES = 4;

    localparam int OFF_W    = $clog2(WORDS);
    localparam int BYTE_OFF = $clog2(DATA_W / 8);
    localparam int BLK_W    = ADDR_W - OFF_W - BYTE_OFF;
    localparam int PTR_W    = $clog2(ENTRIES);
    localparam int CNT_W    = PTR_W + 1;

    typedef struct packed {
        logic                           valid;
        logic                           io;
        logic [BLK_W-1:0]               blk;
        logic [WORDS-1:0]               mask;
        logic [WORDS-1:0][DATA_W-1:0]   data;
    } entry_t;
endpackage

// File: rtl/mwb_match.sv
module mwb_match
    import mwb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  entry_t [ENTRIES-1:0]     slots,
    input  logic [PTR_W-1:0]         head,
    input  logic                     busy,
    input  logic [BLK_W-1:0]         st_blk,
    input  logic                     st_io,
    output logic                     hit,
    output logic [PTR_W-1:0]         hit_idx
);
    logic [ENTRIES-1:0] cand;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign cand[i] = slots[i].valid && !slots[i].io && !st_io &&
                         (slots[i].blk == st_blk) &&
                         !(busy && (head == PTR_W'(i)));
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit     = 1'b1;
                hit_idx = PTR_W'(i);
            end
        end
    end

    // R7: the slot on offer to memory is never a merge target
    p_hit_not_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && busy) |-> (hit_idx != head));

    // R3: a block is pending in at most one mergeable slot
    p_single_cand_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cand));
endmodule

// File: rtl/mwb_drain_mux.sv
module mwb_drain_mux
    import mwb_pkg::*;
(
    input  entry_t [ENTRIES-1:0]     slots,
    input  logic [PTR_W-1:0]         head,
    output logic                     out_valid,
    output logic [ADDR_W-1:0]        out_addr,
    output logic [WORDS*DATA_W-1:0]  out_data,
    output logic [WORDS-1:0]         out_mask
);
    entry_t sel;
    logic   unused_io;

    assign sel       = slots[head];
    assign unused_io = sel.io;
    assign out_valid = sel.valid;
    assign out_addr  = {sel.blk, {(OFF_W + BYTE_OFF){1'b0}}};
    assign out_data  = sel.data;
    assign out_mask  = sel.mask;
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
    import mwb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     st_valid,
    input  logic [ADDR_W-1:0]        st_addr,
    input  logic [DATA_W-1:0]        st_data,
    output logic                     st_stall,
    output logic                     mem_valid,
    input  logic                     mem_ready,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [WORDS*DATA_W-1:0]  mem_data,
    output logic [WORDS-1:0]         mem_wmask
);
    typedef struct packed {
        entry_t [ENTRIES-1:0]   ent;
        logic [PTR_W-1:0]       head;
        logic [PTR_W-1:0]       tail;
        logic [CNT_W-1:0]       count;
    } state_t;

    state_t q, d;

    logic [BLK_W-1:0]     st_blk;
    logic [OFF_W-1:0]     st_word;
    logic                 st_io;
    logic                 hit;
    logic [PTR_W-1:0]     hit_idx;
    logic                 full;
    logic                 pop;
    logic                 push;
    logic                 merge;
    logic                 unused_low;

    assign st_blk     = st_addr[ADDR_W-1 -: BLK_W];
    assign st_word    = st_addr[BYTE_OFF +: OFF_W];
    assign st_io      = st_addr[ADDR_W-1];
    assign unused_low = ^st_addr[BYTE_OFF-1:0];

    mwb_match u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .slots   (q.ent),
        .head    (q.head),
        .busy    (mem_valid),
        .st_blk  (st_blk),
        .st_io   (st_io),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    mwb_drain_mux u_drain (
        .slots     (q.ent),
        .head      (q.head),
        .out_valid (mem_valid),
        .out_addr  (mem_addr),
        .out_data  (mem_data),
        .out_mask  (mem_wmask)
    );

    assign full     = (q.count == CNT_W'(ENTRIES));
    assign merge    = st_valid && hit;
    assign push     = st_valid && !hit && !full;
    assign st_stall = st_valid && !hit && full;
    assign pop      = mem_valid && mem_ready;

    always_comb begin
        d = q;
        if (merge) begin
            d.ent[hit_idx].data[st_word] = st_data;
            d.ent[hit_idx].mask[st_word] = 1'b1;
        end
        if (push) begin
            d.ent[q.tail].valid          = 1'b1;
            d.ent[q.tail].io             = st_io;
            d.ent[q.tail].blk            = st_blk;
            d.ent[q.tail].mask           = '0;
            d.ent[q.tail].mask[st_word]  = 1'b1;
            d.ent[q.tail].data           = '0;
            d.ent[q.tail].data[st_word]  = st_data;
            d.tail                       = q.tail + PTR_W'(1);
        end
        if (pop) begin
            d.ent[q.head].valid = 1'b0;
            d.head              = q.head + PTR_W'(1);
        end
        case ({push, pop})
            2'b10:   d.count = q.count + CNT_W'(1);
            2'b01:   d.count = q.count - CNT_W'(1);
            default: d.count = q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R1: an empty buffer offers nothing to memory
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.count == '0) |-> !mem_valid);

    // R7: the offered slot holds steady until taken
    p_hold_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_wmask)));

    // R5: I/O slots never carry more than one word
    p_io_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_addr[ADDR_W-1]) |-> ($countones(mem_wmask) == 1));

    // R8: stall only when every slot is taken
    p_stall_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> (q.count == CNT_W'(ENTRIES)));

    // R10: occupancy never passes the slot count
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= CNT_W'(ENTRIES));

    // R2: every offered slot writes at least one word
    p_mask_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_wmask != '0));
endmodule

// File: tb/merge_wbuf_tb.sv
module merge_wbuf_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         st_valid;
    logic [31:0]  st_addr;
    logic [31:0]  st_data;
    logic         st_stall;
    logic         mem_valid;
    logic         mem_ready;
    logic [31:0]  mem_addr;
    logic [127:0] mem_data;
    logic [3:0]   mem_wmask;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    merge_wbuf u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_valid  (st_valid),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .st_stall  (st_stall),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_wmask (mem_wmask)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] wd(input int w, input logic [31:0] v);
        logic [127:0] r = '0;
        r[w*32 +: 32] = v;
        return r;
    endfunction

    // one-cycle store; checks the stall against the expected value
    task automatic store(input string tag, input logic [31:0] a, input logic [31:0] v,
                         input logic exp_stall);
        @(negedge clk);
        st_valid = 1'b1;
        st_addr  = a;
        st_data  = v;
        #1;
        chk(tag, {127'd0, st_stall}, {127'd0, exp_stall});
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    // one drain beat; checks the offered slot then takes it
    task automatic drain(input string tag, input logic [31:0] ea, input logic [3:0] em,
                         input logic [127:0] ed);
        @(negedge clk);
        chk({tag, " valid"}, {127'd0, mem_valid}, 128'd1);
        chk({tag, " addr"}, {96'd0, mem_addr}, {96'd0, ea});
        chk({tag, " mask"}, {124'd0, mem_wmask}, {124'd0, em});
        chk({tag, " data"}, mem_data, ed);
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
    endtask

    task automatic expect_empty(input string tag);
        @(negedge clk);
        chk(tag, {127'd0, mem_valid}, 128'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 reset mem_valid", {127'd0, mem_valid}, 128'd0);
        chk("R1 reset stall", {127'd0, st_stall}, 128'd0);
    endtask

    task automatic t_basic;
        store("R2 basic stall", 32'h0000_0104, 32'hA1A1_0001, 1'b0);
        drain("R2 basic", 32'h0000_0100, 4'b0010, wd(1, 32'hA1A1_0001));
        expect_empty("R10 empty after basic");
    endtask

    task automatic t_merge;
        store("R6 filler", 32'h0000_0300, 32'hF0F0_0000, 1'b0);
        store("R3 first", 32'h0000_0200, 32'h1111_1111, 1'b0);
        store("R3 merge w2", 32'h0000_0208, 32'h2222_2222, 1'b0);
        store("R4 overwrite w0", 32'h0000_0200, 32'h3333_3333, 1'b0);
        drain("R6 oldest first", 32'h0000_0300, 4'b0001, wd(0, 32'hF0F0_0000));
        drain("R3 R4 merged", 32'h0000_0200, 4'b0101,
              wd(0, 32'h3333_3333) | wd(2, 32'h2222_2222));
        expect_empty("R10 empty after merge");
    endtask

    task automatic t_io;
        store("R5 io a", 32'h8000_0000, 32'hC000_0001, 1'b0);
        store("R5 io b", 32'h8000_0004, 32'hC000_0002, 1'b0);
        store("R5 io c", 32'h8000_0008, 32'hC000_0003, 1'b0);
        store("R5 io d", 32'h8000_0004, 32'hC000_0004, 1'b0);
        drain("R5 io a", 32'h8000_0000, 4'b0001, wd(0, 32'hC000_0001));
        drain("R5 io b", 32'h8000_0000, 4'b0010, wd(1, 32'hC000_0002));
        drain("R5 io c", 32'h8000_0000, 4'b0100, wd(2, 32'hC000_0003));
        drain("R5 io d", 32'h8000_0000, 4'b0010, wd(1, 32'hC000_0004));
        expect_empty("R10 empty after io");
    endtask

    task automatic t_head_frozen;
        store("R7 head", 32'h0000_0400, 32'hAAAA_0000, 1'b0);
        store("R7 same block", 32'h0000_0404, 32'hBBBB_0001, 1'b0);
        @(negedge clk);
        chk("R7 head mask held", {124'd0, mem_wmask}, 128'h1);
        chk("R7 head data held", mem_data, wd(0, 32'hAAAA_0000));
        drain("R7 head", 32'h0000_0400, 4'b0001, wd(0, 32'hAAAA_0000));
        drain("R7 second slot", 32'h0000_0400, 4'b0010, wd(1, 32'hBBBB_0001));
        expect_empty("R10 empty after frozen");
    endtask

    task automatic t_full;
        store("R8 fill 0", 32'h0000_0500, 32'h5000_0000, 1'b0);
        store("R8 fill 1", 32'h0000_0600, 32'h6000_0000, 1'b0);
        store("R8 fill 2", 32'h0000_0700, 32'h7000_0000, 1'b0);
        store("R8 fill 3", 32'h0000_0800, 32'h8000_0000, 1'b0);
        store("R8 new block stalls", 32'h0000_0900, 32'h9000_0000, 1'b1);
        store("R9 merge when full", 32'h0000_0604, 32'h6000_0001, 1'b0);
        store("R8 head block stalls", 32'h0000_0504, 32'h5000_0001, 1'b1);
        store("R8 io stalls", 32'h8000_0600, 32'hE000_0000, 1'b1);
        drain("R8 slot 0", 32'h0000_0500, 4'b0001, wd(0, 32'h5000_0000));
        drain("R9 slot 1", 32'h0000_0600, 4'b0011,
              wd(0, 32'h6000_0000) | wd(1, 32'h6000_0001));
        drain("R8 slot 2", 32'h0000_0700, 4'b0001, wd(0, 32'h7000_0000));
        drain("R8 slot 3", 32'h0000_0800, 4'b0001, wd(0, 32'h8000_0000));
        expect_empty("R8 stalled stores not taken");
    endtask

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        st_valid  = 1'b0;
        st_addr   = '0;
        st_data   = '0;
        mem_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_merge();
        t_io();
        t_head_frozen();
        t_full();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule